// File: doc/BRIEF.md
# Serial Link Request Packet Framer

This block turns queued link requests into a byte-wide symbol stream for a point-to-point serial link. Each symbol is an 8-bit value plus a flag that marks it as a control symbol. The stream feeds an 8b/10b encoder. When no request is in flight, the framer sends the idle control symbol on every transfer, so the link never goes silent.

A request is offered with a 4-bit type, a byte address and a word count minus one. Write-class requests pull their payload one 32-bit word at a time, with byte enables, from a data FIFO through a pop strobe. The data is assumed present when popped. Each packet is built from these parts, in order:
- a command symbol;
- an optional count symbol, for bursts only;
- the address, most significant byte first;
- the payload, least significant byte first;
- an end delimiter.

Bytes whose enable is low go out as a mask control symbol. The only exception is the full-word write type, which ignores enables. Downstream backpressure freezes the stream.

Top module: `pkt_framer`

## Requirements
- R1: Out of reset the output is the idle control symbol (`sym_ctl_o`=1, `sym_o`=K_IDLE), and `cmd_ready_o` equals `sym_ready_i`.
- R2: Whenever no packet is in progress, every transferred symbol is the idle control symbol.
- R3: The first packet symbol is data `{type[3:0], 3'b000, burst}`. `burst` is 1 when the word count is above one. For a burst, the next data symbol is the word count minus one. A single-word packet therefore has 6 non-payload symbols, and a burst has 7.
- R4: The address follows as ADDR_BYTES data symbols, most significant byte first.
- R5: Payload words are popped one per word, in FIFO order. `wdat_pop_o` is high in the cycle whose transfer completes the symbol before that word. Each word goes out byte 0 first.
- R6: For types 0001 (write), 0101 (configuration write) and 0111 (interrupt), a payload byte whose enable bit is 0 is sent as control symbol K_MASK.
- R7: For type 0011 (full-word write), every payload byte is sent as data regardless of its enable.
- R8: A type 1001 (read) packet carries no payload and never asserts `wdat_pop_o`.
- R9: Every packet ends with control symbol K_END, after which the framer returns to idle.
- R10: A request with any other type is consumed and dropped. It produces no symbols and pops no data.
- R11: While `sym_ready_i` is low, `sym_o` and `sym_ctl_o` hold their value. `cmd_ready_o` is high only when no packet is in progress and `sym_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Request offered |
| cmd_ready_o | output | 1 | Request taken at this edge when valid |
| cmd_type_i | input | 4 | Packet type code |
| cmd_addr_i | input | 8*ADDR_BYTES | Target byte address |
| cmd_len_i | input | LEN_W | Word count minus one |
| wdat_i | input | 8*WORD_BYTES | Head word of the payload FIFO |
| wbe_i | input | WORD_BYTES | Byte enables of the head word |
| wdat_pop_o | output | 1 | Consume the head payload word |
| sym_o | output | 8 | Symbol value |
| sym_ctl_o | output | 1 | Symbol is a control code |
| sym_ready_i | input | 1 | Downstream takes the symbol at this edge |

## Verification
Two events can share a cycle: a payload pop and a downstream stall. A stall can also land on the last address byte, a word boundary or the end delimiter. The bench drops `sym_ready_i` at random on three cycles in four while random bursts of mixed types run. Every transferred symbol is compared with a stream predicted from the requests. Every stalled cycle is judged by comparing the held symbol with the one before it, and the total pop count must match the words queued.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_CMD, PH_CNT, PH_ADDR, PH_DATA, PH_END} phase_e;

  localparam logic [3:0] TY_WR   = 4'b0001;
  localparam logic [3:0] TY_WR32 = 4'b0011;
  localparam logic [3:0] TY_CFG  = 4'b0101;
  localparam logic [3:0] TY_IRQ  = 4'b0111;
  localparam logic [3:0] TY_RD   = 4'b1001;

  function automatic logic type_ok(input logic [3:0] t);
    return (t == TY_WR) || (t == TY_WR32) || (t == TY_CFG) || (t == TY_IRQ) || (t == TY_RD);
  endfunction
endpackage

// File: rtl/pkt_seq.sv
module pkt_seq import pkt_framer_pkg::*; #(
  parameter int ADDR_BYTES = 4,
  parameter int WORD_BYTES = 4,
  parameter int LEN_W      = 4,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int DW = 8 * WORD_BYTES,
  localparam int IW = $clog2(ADDR_BYTES > WORD_BYTES ? ADDR_BYTES : WORD_BYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [3:0]            cmd_type_i,
  input  logic [AW-1:0]         cmd_addr_i,
  input  logic [LEN_W-1:0]      cmd_len_i,
  output logic                  cmd_ready_o,
  input  logic [DW-1:0]         wdat_i,
  input  logic [WORD_BYTES-1:0] wbe_i,
  output logic                  wdat_pop_o,
  input  logic                  sym_ready_i,
  output phase_e                phase_o,
  output logic [IW-1:0]         idx_o,
  output logic [3:0]            type_o,
  output logic [AW-1:0]         addr_o,
  output logic [LEN_W-1:0]      len_o,
  output logic [DW-1:0]         word_o,
  output logic [WORD_BYTES-1:0] be_o
);
  phase_e                phase_q;
  logic [IW-1:0]         idx_q;
  logic [LEN_W-1:0]      left_q, len_q;
  logic [3:0]            type_q;
  logic [AW-1:0]         addr_q;
  logic [DW-1:0]         word_q;
  logic [WORD_BYTES-1:0] be_q;
  logic                  is_rd, last_byte;

  assign is_rd       = (type_q == TY_RD);
  assign last_byte   = (idx_q == IW'(WORD_BYTES - 1));
  assign cmd_ready_o = (phase_q == PH_IDLE) && sym_ready_i;
  // fetch next word as the symbol before it leaves
  assign wdat_pop_o  = sym_ready_i &&
                       (((phase_q == PH_ADDR) && (idx_q == '0) && !is_rd) ||
                        ((phase_q == PH_DATA) && last_byte && (left_q != '0)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      left_q  <= '0;
      len_q   <= '0;
      type_q  <= '0;
      addr_q  <= '0;
      word_q  <= '0;
      be_q    <= '0;
    end else begin
      if (wdat_pop_o) begin
        word_q <= wdat_i;
        be_q   <= wbe_i;
      end
      if (sym_ready_i) begin
        case (phase_q)
          PH_IDLE: if (cmd_valid_i && type_ok(cmd_type_i)) begin
            phase_q <= PH_CMD;
            type_q  <= cmd_type_i;
            addr_q  <= cmd_addr_i;
            len_q   <= cmd_len_i;
            left_q  <= cmd_len_i;
          end
          PH_CMD: begin
            phase_q <= (len_q != '0) ? PH_CNT : PH_ADDR;
            idx_q   <= IW'(ADDR_BYTES - 1);
          end
          PH_CNT: begin
            phase_q <= PH_ADDR;
            idx_q   <= IW'(ADDR_BYTES - 1);
          end
          PH_ADDR: begin
            if (idx_q == '0) begin
              phase_q <= is_rd ? PH_END : PH_DATA;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
          PH_DATA: begin
            if (last_byte) begin
              if (left_q != '0) begin
                left_q <= left_q - 1'b1;
                idx_q  <= '0;
              end else begin
                phase_q <= PH_END;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          PH_END:  phase_q <= PH_IDLE;
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign type_o  = type_q;
  assign addr_o  = addr_q;
  assign len_o   = len_q;
  assign word_o  = word_q;
  assign be_o    = be_q;

  AST_POP_STARTS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdat_pop_o |=> (phase_q == PH_DATA) && (idx_q == '0)); // R5
  AST_READ_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && (phase_q != PH_IDLE)) |-> !wdat_pop_o); // R8
  AST_END_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_END) && sym_ready_i) |=> (phase_q == PH_IDLE)); // R9
  AST_DROP_BAD_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && cmd_valid_i && !type_ok(cmd_type_i)) |=> (phase_q == PH_IDLE)); // R10
endmodule

// File: rtl/pkt_sym_mux.sv
module pkt_sym_mux import pkt_framer_pkg::*; #(
  parameter int         ADDR_BYTES = 4,
  parameter int         WORD_BYTES = 4,
  parameter int         LEN_W      = 4,
  parameter logic [7:0] K_IDLE     = 8'hBC,
  parameter logic [7:0] K_END      = 8'hFD,
  parameter logic [7:0] K_MASK     = 8'hF7,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int DW = 8 * WORD_BYTES,
  localparam int IW = $clog2(ADDR_BYTES > WORD_BYTES ? ADDR_BYTES : WORD_BYTES)
) (
  input  phase_e                phase_i,
  input  logic [IW-1:0]         idx_i,
  input  logic [3:0]            type_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [LEN_W-1:0]      len_i,
  input  logic [DW-1:0]         word_i,
  input  logic [WORD_BYTES-1:0] be_i,
  output logic [7:0]            sym_o,
  output logic                  sym_ctl_o
);
  always_comb begin
    sym_o     = K_IDLE;
    sym_ctl_o = 1'b1;
    case (phase_i)
      PH_CMD: begin
        sym_o     = {type_i, 3'b000, (len_i != '0)};
        sym_ctl_o = 1'b0;
      end
      PH_CNT: begin
        sym_o     = 8'(len_i);
        sym_ctl_o = 1'b0;
      end
      PH_ADDR: begin
        sym_o     = addr_i[8*int'(idx_i) +: 8];
        sym_ctl_o = 1'b0;
      end
      PH_DATA: begin
        if ((type_i != TY_WR32) && !be_i[idx_i]) begin
          sym_o = K_MASK;
        end else begin
          sym_o     = word_i[8*int'(idx_i) +: 8];
          sym_ctl_o = 1'b0;
        end
      end
      PH_END:  sym_o = K_END;
      default: sym_o = K_IDLE;
    endcase
  end

  always_comb begin
    if (phase_i == PH_CMD) begin
      AST_CMD_TYPE_LEGAL: assert (type_ok(type_i)); // R10
    end
  end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer import pkt_framer_pkg::*; #(
  parameter int         ADDR_BYTES = 4,
  parameter int         WORD_BYTES = 4,
  parameter int         LEN_W      = 4,
  parameter logic [7:0] K_IDLE     = 8'hBC,
  parameter logic [7:0] K_END      = 8'hFD,
  parameter logic [7:0] K_MASK     = 8'hF7,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int DW = 8 * WORD_BYTES,
  localparam int IW = $clog2(ADDR_BYTES > WORD_BYTES ? ADDR_BYTES : WORD_BYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  output logic                  cmd_ready_o,
  input  logic [3:0]            cmd_type_i,
  input  logic [AW-1:0]         cmd_addr_i,
  input  logic [LEN_W-1:0]      cmd_len_i,
  input  logic [DW-1:0]         wdat_i,
  input  logic [WORD_BYTES-1:0] wbe_i,
  output logic                  wdat_pop_o,
  output logic [7:0]            sym_o,
  output logic                  sym_ctl_o,
  input  logic                  sym_ready_i
);
  phase_e                phase;
  logic [IW-1:0]         idx;
  logic [3:0]            ty;
  logic [AW-1:0]         addr;
  logic [LEN_W-1:0]      len;
  logic [DW-1:0]         word;
  logic [WORD_BYTES-1:0] be;

  pkt_seq #(.ADDR_BYTES(ADDR_BYTES), .WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W)) u_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_type_i, .cmd_addr_i, .cmd_len_i, .cmd_ready_o,
    .wdat_i, .wbe_i, .wdat_pop_o, .sym_ready_i,
    .phase_o(phase), .idx_o(idx), .type_o(ty), .addr_o(addr), .len_o(len),
    .word_o(word), .be_o(be)
  );

  pkt_sym_mux #(.ADDR_BYTES(ADDR_BYTES), .WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W),
                .K_IDLE(K_IDLE), .K_END(K_END), .K_MASK(K_MASK)) u_mux (
    .phase_i(phase), .idx_i(idx), .type_i(ty), .addr_i(addr), .len_i(len),
    .word_i(word), .be_i(be), .sym_o, .sym_ctl_o
  );

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_ready_i |=> $stable(sym_o) && $stable(sym_ctl_o)); // R11
  AST_NO_TAKE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_IDLE) |-> !cmd_ready_o); // R11
endmodule

// File: tb/sim_pkt_framer.sv
module sim_pkt_framer;
  localparam logic [7:0] KI = 8'hBC, KE = 8'hFD, KM = 8'hF7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [3:0] cmd_type = '0;
  logic [31:0] cmd_addr = '0;
  logic [3:0] cmd_len = '0;
  logic [31:0] wdat;
  logic [3:0] wbe;
  logic wpop, sym_ctl, sym_ready = 1'b1;
  logic [7:0] sym;

  int checks = 0, failures = 0;
  bit bp_en = 1'b0, mon_on = 1'b0;

  logic [31:0] fd [0:1023];
  logic [3:0]  fb [0:1023];
  int wr_p = 0, rd_p = 0;
  logic [8:0] exp_q [$];
  string tag_q [$];
  logic [8:0] prev_s = '0;
  bit prev_rdy = 1'b1;

  always #2 clk = ~clk;

  pkt_framer u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_type_i(cmd_type), .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len),
    .wdat_i(wdat), .wbe_i(wbe), .wdat_pop_o(wpop),
    .sym_o(sym), .sym_ctl_o(sym_ctl), .sym_ready_i(sym_ready)
  );

  assign wdat = fd[rd_p[9:0]];
  assign wbe  = fb[rd_p[9:0]];
  always @(posedge clk) if (rst_n && wpop) rd_p <= rd_p + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input logic [3:0] t);
    return t == 4'b0001 || t == 4'b0011 || t == 4'b0101 || t == 4'b0111 || t == 4'b1001;
  endfunction

  // ready driver and stream monitor
  always begin
    @(negedge clk);
    sym_ready = bp_en ? (($urandom % 4) == 0) : 1'b1;
    #1;
    if (mon_on) begin
      if (!prev_rdy)
        check({sym_ctl, sym} == prev_s, "R11 hold", {23'd0, sym_ctl, sym}, {23'd0, prev_s});
      if (sym_ready && !(sym_ctl && sym == KI)) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected symbol", {23'd0, sym_ctl, sym}, {23'd0, 1'b1, KI});
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({sym_ctl, sym} == e, t, {23'd0, sym_ctl, sym}, {23'd0, e});
        end
      end
      if (!sym_ready && !bp_en)
        check(1'b0, "R11 ready", 0, 1);
      if (cmd_ready && !sym_ready)
        check(1'b0, "R11 cmd_ready while stalled", 1, 0);
    end
    prev_s = {sym_ctl, sym};
    prev_rdy = sym_ready;
  end

  task automatic push(input logic [8:0] s, input string t);
    exp_q.push_back(s);
    tag_q.push_back(t);
  endtask

  task automatic send(input logic [3:0] t, input logic [31:0] a, input logic [3:0] l,
                      input bit fixed_be, input logic [3:0] be);
    bit took;
    if (legal(t)) begin
      push({1'b0, t, 3'b000, (l != 0)}, "R3 cmd");
      if (l != 0) push({1'b0, 4'h0, l}, "R3 count");
      for (int i = 3; i >= 0; i--) push({1'b0, a[8*i +: 8]}, "R4 addr");
      if (t != 4'b1001) begin
        for (int w = 0; w <= int'(l); w++) begin
          logic [31:0] d;
          logic [3:0] b;
          d = $urandom;
          b = fixed_be ? be : 4'($urandom);
          fd[wr_p[9:0]] = d;
          fb[wr_p[9:0]] = b;
          wr_p++;
          for (int k = 0; k < 4; k++) begin
            if (t == 4'b0011) push({1'b0, d[8*k +: 8]}, "R7 full word");
            else if (!b[k])   push({1'b1, KM}, "R6 mask");
            else              push({1'b0, d[8*k +: 8]}, "R5 data");
          end
        end
      end
      push({1'b1, KE}, "R9 end");
    end
    took = 1'b0;
    while (!took) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_type = t; cmd_addr = a; cmd_len = l;
      #1;
      took = cmd_ready;
      @(posedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    check(exp_q.size() == 0, "R2 stream complete", exp_q.size(), 0);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    repeat (149000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int pops_before;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(sym_ctl == 1'b1 && sym == KI, "R1 idle in reset", {23'd0, sym_ctl, sym}, {23'd0, 1'b1, KI});
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(sym_ctl == 1'b1 && sym == KI, "R1 idle after reset", {23'd0, sym_ctl, sym}, {23'd0, 1'b1, KI});
    check(cmd_ready == sym_ready, "R1 cmd_ready", cmd_ready, sym_ready);
    mon_on = 1'b1;

    send(4'b0001, 32'h8200_0054, 4'd0, 1'b1, 4'hF);   // R3 single write
    send(4'b0001, 32'h1234_5678, 4'd0, 1'b1, 4'b0101); // R6
    send(4'b0011, 32'hCAFE_0000, 4'd1, 1'b1, 4'h0);  // R7
    send(4'b0101, 32'h0000_0014, 4'd2, 1'b0, 4'h0);
    send(4'b0111, 32'h0000_0010, 4'd0, 1'b1, 4'b1000);
    drain();
    pops_before = rd_p;
    send(4'b1001, 32'h4C00_0100, 4'd0, 1'b1, 4'h0);  // R8
    send(4'b1001, 32'h4C00_0200, 4'd15, 1'b1, 4'h0);
    drain();
    check(rd_p == pops_before, "R8 read pops", rd_p, pops_before);
    send(4'b0110, 32'hDEAD_BEEF, 4'd3, 1'b1, 4'hF);  // R10
    send(4'b0000, 32'hDEAD_BEEF, 4'd0, 1'b1, 4'hF);
    repeat (20) @(posedge clk);
    check(rd_p == pops_before, "R10 no pop", rd_p, pops_before);
    send(4'b0001, 32'hFFFF_FFFC, 4'd15, 1'b0, 4'h0); // R3 max burst

    bp_en = 1'b1;
    for (int n = 0; n < 40; n++) begin
      logic [3:0] t;
      int r;
      r = $urandom % 7;
      t = (r == 0) ? 4'b0001 : (r == 1) ? 4'b0011 : (r == 2) ? 4'b0101 :
          (r == 3) ? 4'b0111 : (r == 4) ? 4'b1001 : (r == 5) ? 4'b1000 : 4'b0001;
      send(t, $urandom, 4'($urandom), 1'b0, 4'h0);
    end
    drain();
    bp_en = 1'b0;
    drain();
    check(rd_p == wr_p, "R5 pop count", rd_p, wr_p);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule